// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block walks an analog-to-digital converter through its two timed phases: a sampling window, then a successive-comparison window. A single 8-bit configuration register picks how conversions repeat, which inputs may start them, and how many clock cycles each phase lasts. The phase lengths are coded in two bits each and map onto uneven cycle counts, so the same clock can serve converters with different settling needs.

A conversion can be started by a software strobe, and also, if the register allows it, by a falling edge on an external pin or by a rising edge on a timer line. Both outside lines pass through a two-stage synchronizer before their edges are detected. While a conversion runs, `sample_en_o` and then `compare_en_o` are held high for the programmed number of cycles. At the end, `done_o` pulses for one cycle and the result is latched. A simple behavioural stub takes the place of the analog core and supplies a result at the end of each compare phase.

The repeat behaviour has four forms: one-shot with restart allowed, one-shot with starts locked out while busy, free-running, and one-shot that parks in a paused state between runs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x0F, no conversion is running, and `sample_en_o`, `compare_en_o`, `busy_o` and `done_o` are all low.
- R2: A write stores all eight bits, and `cfg_rdata_o` returns the stored value from the cycle after the write onwards.
- R3: Bits [1:0] set the sampling phase length: code 0 gives 9 cycles, 1 gives 15, 2 gives 17 and 3 gives 28 cycles of `sample_en_o` high.
- R4: Bits [3:2] set the compare phase length: code 0 gives 12 cycles, 1 gives 18, 2 gives 24 and 3 gives 48. Compare follows sampling directly, and the two enables are never high together.
- R5: In the cycle after the last compare cycle, `done_o` is high for exactly one cycle and `result_o` shows the new result. The stub's n-th result (counting from 0) is (5 + 37·n) mod 1024.
- R6: With mode bits [7:6] = 00, a start during sampling, compare or the done cycle restarts the sampling phase at its full length.
- R7: With mode 01, starts that arrive while a conversion is running or in its done cycle are ignored. After the done cycle the block returns to idle.
- R8: With mode 10, each done cycle is followed directly by a new sampling phase without any trigger. The repeat stops at the first done cycle that sees a different mode.
- R9: With mode 11, after each done cycle the block waits in a paused state with `busy_o` low, and only a valid start resumes it at the sampling phase.
- R10: Bits [5:4] select the starts: 00 allows software only, 01 adds the external falling edge, 10 adds the timer rising edge, and 11 adds both. Edges from a source that is not selected are ignored.
- R11: A falling edge on `ext_trig_i`, or a rising edge on `tmr_trig_i`, with the block idle and that source selected makes `sample_en_o` go high on the third rising clock edge after the input changes.
- R12: Each phase takes its length from the register at the moment the phase is entered, so a write during a conversion only affects phases entered after it.
- R13: `busy_o` is high exactly while sampling, comparing or in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data |
| sw_start_i | input | 1 | Software start strobe, level sampled each cycle |
| ext_trig_i | input | 1 | External trigger pin, asynchronous, falling edge active |
| tmr_trig_i | input | 1 | Timer trigger, asynchronous, rising edge active |
| sample_en_o | output | 1 | High during the sampling phase |
| compare_en_o | output | 1 | High during the compare phase |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse at conversion end |
| result_o | output | 10 | Last conversion result |

## Verification
On every cycle the assertions check that the two phase enables never overlap, that a done pulse lasts one cycle and always follows a compare cycle, that a written value is stored, that synchronized edge pulses last only one cycle, and that the phase counter stays within its table. The restart and lockout rules, the free-running and paused repeat forms, the source filtering and the capture of phase lengths at phase entry depend on how triggers and register writes are ordered over time. Only the bench's scenarios show these, by comparing the outputs against a behavioural model on every cycle and by measuring phase lengths and done counts directly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CNT_W = 6;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h0F;

  typedef enum logic [1:0] {
    MODE_ONE_RESTART = 2'b00,
    MODE_ONE_LOCK    = 2'b01,
    MODE_CONT        = 2'b10,
    MODE_STOP        = 2'b11
  } conv_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_COMPARE,
    ST_DONE,
    ST_PAUSED
  } seq_state_e;

  typedef struct packed {
    conv_mode_e  mode;
    logic [1:0]  src;
    logic [1:0]  cmp_sel;
    logic [1:0]  smp_sel;
  } cfg_t;

  function automatic logic [CNT_W-1:0] smp_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(9);
      2'd1:    return CNT_W'(15);
      2'd2:    return CNT_W'(17);
      default: return CNT_W'(28);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cmp_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(12);
      2'd1:    return CNT_W'(18);
      2'd2:    return CNT_W'(24);
      default: return CNT_W'(48);
    endcase
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int   SYNC_STAGES = 2,
  parameter bit   RISING      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pulse_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  generate
    if (RISING) begin : g_rise
      assign pulse_o = cur & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~cur & prev_q;
    end
  endgenerate

  // R11: one edge gives one single-cycle pulse
  assert_pulse_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);

  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= CFG_RESET;
    else if (we_i) reg_q <= wdata_i;
  end

  assign rdata_o = reg_q;
  assign cfg_o   = cfg_t'(reg_q);

  assert_write_stored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i));

endmodule

// File: rtl/adc_stub.sv
module adc_stub #(
  parameter int RES_W = 10,
  parameter int SEED  = 5,
  parameter int STEP  = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_end_i,
  output logic [RES_W-1:0] data_o
);

  logic [RES_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         val_q <= RES_W'(SEED);
    else if (conv_end_i) val_q <= val_q + RES_W'(STEP);
  end

  assign data_o = val_q;

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  conv_mode_e mode_i,
  input  logic [1:0] smp_sel_i,
  input  logic [1:0] cmp_sel_i,
  input  logic       trig_i,
  output logic       sample_en_o,
  output logic       compare_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       conv_end_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] smp_load, cmp_load;
  logic             restart_ok;

  assign smp_load   = smp_cycles(smp_sel_i) - CNT_W'(1);
  assign cmp_load   = cmp_cycles(cmp_sel_i) - CNT_W'(1);
  assign restart_ok = (mode_i == MODE_ONE_RESTART) && trig_i;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    conv_end_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PAUSED: begin
        if (trig_i) begin
          state_d = ST_SAMPLE;
          cnt_d   = smp_load;
        end
      end
      ST_SAMPLE: begin
        if (restart_ok) begin
          cnt_d = smp_load;
        end else if (cnt_q == '0) begin
          state_d = ST_COMPARE;
          cnt_d   = cmp_load;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_COMPARE: begin
        if (restart_ok) begin
          state_d = ST_SAMPLE;
          cnt_d   = smp_load;
        end else if (cnt_q == '0) begin
          state_d    = ST_DONE;
          conv_end_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (mode_i == MODE_CONT || restart_ok) begin
          state_d = ST_SAMPLE;
          cnt_d   = smp_load;
        end else if (mode_i == MODE_STOP) begin
          state_d = ST_PAUSED;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sample_en_o  = (state_q == ST_SAMPLE);
  assign compare_en_o = (state_q == ST_COMPARE);
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = sample_en_o | compare_en_o | done_o;

  assert_phase_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_en_o && compare_en_o));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(compare_en_o));

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_o |-> cnt_q < CNT_W'(28));

  assert_cmp_from_smp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(compare_en_o) |-> $past(sample_en_o));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             sw_start_i,
  input  logic             ext_trig_i,
  input  logic             tmr_trig_i,
  output logic             sample_en_o,
  output logic             compare_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  cfg_t             cfg;
  logic             ext_fall, tmr_rise, trig, conv_end;
  logic [RES_W-1:0] stub_data;
  logic [RES_W-1:0] result_q;

  adc_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  adc_edge_sync #(.SYNC_STAGES(2), .RISING(1'b0)) u_ext_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (ext_trig_i),
    .pulse_o (ext_fall)
  );

  adc_edge_sync #(.SYNC_STAGES(2), .RISING(1'b1)) u_tmr_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (tmr_trig_i),
    .pulse_o (tmr_rise)
  );

  // src bit 0 enables the pin, bit 1 the timer; software always allowed
  assign trig = sw_start_i | (cfg.src[0] & ext_fall) | (cfg.src[1] & tmr_rise);

  adc_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (cfg.mode),
    .smp_sel_i    (cfg.smp_sel),
    .cmp_sel_i    (cfg.cmp_sel),
    .trig_i       (trig),
    .sample_en_o  (sample_en_o),
    .compare_en_o (compare_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .conv_end_o   (conv_end)
  );

  adc_stub #(.RES_W(RES_W), .SEED(5), .STEP(37)) u_stub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_end_i (conv_end),
    .data_o     (stub_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       result_q <= '0;
    else if (conv_end) result_q <= stub_data;
  end

  assign result_o = result_q;

  assert_result_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> done_o || $stable(result_o));

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sw_start = 1'b0;
  logic       ext_trig = 1'b1;
  logic       tmr_trig = 1'b0;
  logic       sample_en, compare_en, busy, done;
  logic [9:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.RES_W(10)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .sw_start_i   (sw_start),
    .ext_trig_i   (ext_trig),
    .tmr_trig_i   (tmr_trig),
    .sample_en_o  (sample_en),
    .compare_en_o (compare_en),
    .busy_o       (busy),
    .done_o       (done),
    .result_o     (result)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int        m_reg, m_phase, m_left, m_res, m_count;
  bit        p1, p2, p3, q1, q2, q3;
  // phase: 0 idle, 1 sampling, 2 comparing, 3 done, 4 paused

  function automatic int smp_len(input int r);
    int t[4] = '{9, 15, 17, 28};
    return t[r & 3];
  endfunction
  function automatic int cmp_len(input int r);
    int t[4] = '{12, 18, 24, 48};
    return t[(r >> 2) & 3];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h0F; m_phase = 0; m_left = 0; m_res = 0; m_count = 0;
      p1 = 0; p2 = 0; p3 = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      int  md, src;
      bit  go;
      md  = (m_reg >> 6) & 3;
      src = (m_reg >> 4) & 3;
      go  = sw_start || ((src & 1) && p3 && !p2) || ((src & 2) && q2 && !q3);
      case (m_phase)
        0, 4: if (go) begin m_phase = 1; m_left = smp_len(m_reg); end
        1: begin
          if (md == 0 && go) m_left = smp_len(m_reg);
          else if (m_left == 1) begin m_phase = 2; m_left = cmp_len(m_reg); end
          else m_left--;
        end
        2: begin
          if (md == 0 && go) begin m_phase = 1; m_left = smp_len(m_reg); end
          else if (m_left == 1) begin
            m_phase = 3;
            m_res = (5 + 37 * m_count) % 1024;
            m_count++;
          end else m_left--;
        end
        default: begin
          if (md == 2 || (md == 0 && go)) begin m_phase = 1; m_left = smp_len(m_reg); end
          else if (md == 3) m_phase = 4;
          else m_phase = 0;
        end
      endcase
      if (cfg_we) m_reg = cfg_wdata;
      p3 = p2; p2 = p1; p1 = ext_trig;
      q3 = q2; q2 = q1; q1 = tmr_trig;
    end
  end

  // per-cycle compare and phase length monitor
  int run_s = 0, run_c = 0, last_s = 0, last_c = 0, n_done = 0;
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      check(sample_en == (m_phase == 1), "R3 sample_en", sample_en, m_phase == 1);
      check(compare_en == (m_phase == 2), "R4 compare_en", compare_en, m_phase == 2);
      check(done == (m_phase == 3), "R5 done", done, m_phase == 3);
      check(int'(result) == m_res, "R5 result", result, m_res);
      check(busy == (m_phase inside {1, 2, 3}), "R13 busy", busy, m_phase inside {1, 2, 3});
      check(int'(cfg_rdata) == m_reg, "R2 rdata", cfg_rdata, m_reg);
    end
    if (sample_en) run_s++;
    else if (run_s > 0) begin last_s = run_s; run_s = 0; end
    if (compare_en) run_c++;
    else if (run_c > 0) begin last_c = run_c; run_c = 0; end
    if (done) n_done++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(1); cfg_we = 1'b0;
  endtask
  task automatic sw_pulse();
    sw_start = 1'b1; tick(1); sw_start = 1'b0;
  endtask
  task automatic wait_idle();
    while (busy) tick(1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int d0;
    tick(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick(1);
    // R1 reset state
    check(cfg_rdata == 8'h0F, "R1 reset reg", cfg_rdata, 8'h0F);
    check(!busy && !sample_en && !compare_en && !done, "R1 idle", busy, 0);

    // R3 R4 R5 default lengths, software start
    sw_pulse();
    wait_idle();
    tick(2);
    check(last_s == 28, "R3 default sample len", last_s, 28);
    check(last_c == 48, "R4 default compare len", last_c, 48);
    check(n_done == 1, "R5 one done", n_done, 1);
    check(result == 10'd5, "R5 first result", result, 5);

    // R6 restart in mode 00
    wr(8'h00);
    sw_pulse();
    tick(4);
    sw_pulse();
    wait_idle();
    tick(2);
    check(last_s > 9, "R6 restart stretches sample", last_s, 13);
    check(last_c == 12, "R4 compare code 0", last_c, 12);
    check(n_done == 2, "R6 single done", n_done, 2);

    // R7 lockout in mode 01
    wr(8'h45);
    sw_pulse();
    tick(4);  sw_pulse();
    tick(20); sw_pulse();
    wait_idle();
    tick(2);
    check(last_s == 15, "R7 sample not restarted", last_s, 15);
    check(last_c == 18, "R7 compare not restarted", last_c, 18);
    check(n_done == 3, "R7 one done", n_done, 3);

    // R8 R10 continuous with timer start, R12 write mid-run
    wr(8'hA5);
    tmr_trig = 1'b1; tick(4); tmr_trig = 1'b0;
    d0 = n_done;
    while (n_done < d0 + 2) tick(1);
    while (!sample_en) tick(1);
    check(n_done == d0 + 2, "R8 free-running", n_done, d0 + 2);
    tick(3);
    wr(8'h0A);
    wait_idle();
    tick(2);
    check(last_s == 15, "R12 sample kept old length", last_s, 15);
    check(last_c == 24, "R12 compare took new length", last_c, 24);
    tick(40);
    check(!busy, "R8 stops after mode change", busy, 0);

    // R9 R10 R11 stop mode with pin start
    wr(8'hD6);
    tick(4);
    ext_trig = 1'b0;
    tick(2);
    check(!sample_en, "R11 not yet sampling", sample_en, 0);
    tick(1);
    check(sample_en, "R11 sampling on third edge", sample_en, 1);
    ext_trig = 1'b1;
    d0 = n_done;
    while (n_done == d0) tick(1);
    tick(3);
    check(!busy, "R9 paused not busy", busy, 0);
    tmr_trig = 1'b1; tick(5); tmr_trig = 1'b0;
    tick(60);
    check(n_done == d0 + 1, "R10 timer ignored with src 01", n_done, d0 + 1);
    sw_pulse();
    tick(1);
    check(sample_en, "R9 resume on start", sample_en, 1);
    wait_idle();

    // R10 pin ignored with software-only source
    wr(8'h03);
    ext_trig = 1'b0; tick(6); ext_trig = 1'b1;
    tick(4);
    check(!busy, "R10 pin ignored with src 00", busy, 0);

    // R2 readback
    wr(8'h3C);
    check(cfg_rdata == 8'h3C, "R2 readback", cfg_rdata, 8'h3C);
    wr(8'hFF);
    check(cfg_rdata == 8'hFF, "R2 readback all ones", cfg_rdata, 8'hFF);
    tick(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule